// File: doc/BRIEF.md
# Processor Status and Control Flags Unit

This block holds a 16-bit processor flags word. The word carries six status flags and three control flags. When the arithmetic unit finishes an operation, the block derives the status flags from the operands, the result and two carry signals that the arithmetic unit supplies. The rules that apply depend on an operation class: add, subtract or compare, increment or decrement, logical, shift or rotate, and divide. A size select chooses between byte and word results.

The block also carries out single-flag commands. These clear, set or invert the carry flag, clear or set the interrupt-enable flag, and clear or set the direction flag. A load strobe replaces the whole word, which serves the pop-flags path. The push-flags path reads the registered word from the output. Every change is registered and shows on the output one clock after its strobe.

Top module: `flagword_unit`

## Requirements
- R1: After reset the word is 16'h0022. Bit positions: carry 0, parity 2, auxiliary 4, zero 6, sign 7, trap 8, interrupt-enable 9, direction 10, overflow 11.
- R2: Bits 1 and 5 always read 1. Bits 3 and 15 down to 12 always read 0, even after a load that writes them.
- R3: For class add (0) and sub/compare (1), carry equals `c_out`. Overflow equals `c_into_msb` XOR `c_out`. Auxiliary equals bit 4 of `opa` XOR `opb` XOR `res`.
- R4: Sign is the result MSB, which is bit 15 when `is_word`=1 and bit 7 otherwise. Zero is set only when the result bits of that size are all 0. In byte mode, result bits 15:8 have no effect.
- R5: Parity is 1 when `res[7:0]` has an even number of ones, in both sizes.
- R6: Class inc/dec (2) updates sign, zero, auxiliary, parity and overflow by the R3 rules, and leaves carry unchanged.
- R7: Class logical (3) clears carry, overflow and auxiliary. Sign, zero and parity still follow R4 and R5.
- R8: Class shift/rotate (4) sets carry to `c_out`, which is the bit shifted out. Overflow becomes the result MSB XOR `c_out`. Auxiliary is kept.
- R9: Class divide (5) leaves the trap, interrupt-enable and direction flags unchanged. The status flags after a divide carry no defined value.
- R10: With `cmd_valid`, `cmd` takes these codes: 0 clears carry, 1 sets carry, 2 inverts carry, 3 clears interrupt-enable, 4 sets interrupt-enable, 5 clears direction, 6 sets direction, 7 does nothing. Each command changes only its own bit.
- R11: `load` writes the nine active bits from `load_word`. The other bits are forced to their fixed values.
- R12: When strobes coincide, `load` wins over `cmd_valid`, and `cmd_valid` wins over `upd`. Every change appears on `flags` one clock after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd | input | 1 | Update the status flags from the ALU inputs |
| op_class | input | 3 | Operation class, encoded as in R3, R6 to R9 |
| is_word | input | 1 | 1 selects a 16-bit result, 0 selects an 8-bit result |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| res | input | 16 | ALU result |
| c_out | input | 1 | Carry or borrow out of the MSB, or the bit shifted out |
| c_into_msb | input | 1 | Carry into the MSB |
| cmd_valid | input | 1 | Execute a single-flag command |
| cmd | input | 3 | Single-flag command code |
| load | input | 1 | Load the whole word |
| load_word | input | 16 | Word to load |
| flags | output | 16 | Flags word |

## Verification
Every result is due exactly one clock after its strobe, because the word passes through a single register. The bench drives each strobe on a falling edge and removes it on the next falling edge. It reads `flags` at that same falling edge, half a cycle after the capturing rising edge. Every vector first loads a known word through `load`, which also takes one cycle, so each update starts from a known state. Priority is checked by raising several strobes in one cycle and reading the word one cycle later.

// File: rtl/flagword_unit.sv
module flagword_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd,
  input  logic [2:0]  op_class,
  input  logic        is_word,
  input  logic [15:0] opa,
  input  logic [15:0] opb,
  input  logic [15:0] res,
  input  logic        c_out,
  input  logic        c_into_msb,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd,
  input  logic        load,
  input  logic [15:0] load_word,
  output logic [15:0] flags
);
  localparam logic [15:0] ACTIVE = 16'h0FD5;
  localparam logic [15:0] FIXED1 = 16'h0022;
  localparam int B_CF = 0, B_PF = 2, B_AF = 4, B_ZF = 6, B_SF = 7;
  localparam int B_IF = 9, B_DF = 10, B_OF = 11;
  localparam logic [2:0] C_ADD = 3'd0, C_SUB = 3'd1, C_INC = 3'd2,
                         C_LOG = 3'd3, C_SHF = 3'd4, C_DIV = 3'd5;

  logic [15:0] q, nxt;

  wire msb    = is_word ? res[15] : res[7];
  wire zero   = is_word ? (res == 16'h0) : (res[7:0] == 8'h0);
  wire parity = ~^res[7:0];
  wire aux    = opa[4] ^ opb[4] ^ res[4];
  wire ovf    = c_into_msb ^ c_out;

  always_comb begin
    nxt = q;
    if (load) begin
      nxt = load_word;
    end else if (cmd_valid) begin
      case (cmd)
        3'd0: nxt[B_CF] = 1'b0;
        3'd1: nxt[B_CF] = 1'b1;
        3'd2: nxt[B_CF] = ~q[B_CF];
        3'd3: nxt[B_IF] = 1'b0;
        3'd4: nxt[B_IF] = 1'b1;
        3'd5: nxt[B_DF] = 1'b0;
        3'd6: nxt[B_DF] = 1'b1;
        default: ;
      endcase
    end else if (upd) begin
      case (op_class)
        C_ADD, C_SUB, C_INC: begin
          if (op_class != C_INC) nxt[B_CF] = c_out;
          nxt[B_OF] = ovf;
          nxt[B_AF] = aux;
          nxt[B_SF] = msb;
          nxt[B_ZF] = zero;
          nxt[B_PF] = parity;
        end
        C_LOG: begin
          nxt[B_CF] = 1'b0;
          nxt[B_OF] = 1'b0;
          nxt[B_AF] = 1'b0;
          nxt[B_SF] = msb;
          nxt[B_ZF] = zero;
          nxt[B_PF] = parity;
        end
        C_SHF: begin
          nxt[B_CF] = c_out;
          nxt[B_OF] = msb ^ c_out;
          nxt[B_SF] = msb;
          nxt[B_ZF] = zero;
          nxt[B_PF] = parity;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 16'h0;
    else        q <= nxt & ACTIVE;
  end

  assign flags = (q & ACTIVE) | FIXED1;

  assert_incdec_keeps_cf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op_class == C_INC && !load && !cmd_valid) |=> flags[B_CF] == $past(flags[B_CF]));

  assert_logic_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op_class == C_LOG && !load && !cmd_valid) |=> (!flags[B_CF] && !flags[B_OF] && !flags[B_AF]));

  assert_div_controls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op_class == C_DIV && !load && !cmd_valid) |=> flags[10:8] == $past(flags[10:8]));

  assert_cmd_one_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !load) |=> $countones(flags ^ $past(flags)) <= 1);

  assert_load_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> flags == (($past(load_word) & 16'h0FD5) | 16'h0022));

  assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op_class == C_ADD && !load && !cmd_valid) |=> flags[B_CF] == $past(c_out));
endmodule

// File: tb/sim_flagword_unit.sv
`timescale 1ns/1ps
module sim_flagword_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0, is_word = 1'b0, c_out = 1'b0, c_into_msb = 1'b0;
  logic cmd_valid = 1'b0, load = 1'b0;
  logic [2:0] op_class = 3'd0, cmd = 3'd7;
  logic [15:0] opa = 16'h0, opb = 16'h0, res = 16'h0, load_word = 16'h0;
  logic [15:0] flags;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  flagword_unit u0 (
    .clk(clk), .rst_n(rst_n), .upd(upd), .op_class(op_class), .is_word(is_word),
    .opa(opa), .opb(opb), .res(res), .c_out(c_out), .c_into_msb(c_into_msb),
    .cmd_valid(cmd_valid), .cmd(cmd), .load(load), .load_word(load_word), .flags(flags)
  );

  // pre, class, word, a, b, r, c_out, c_into_msb, expected, mask
  localparam int NV = 10;
  localparam logic [101:0] VEC [NV] = '{
    {16'h0000, 3'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b1, 1'b1, 16'h0077, 16'hFFFF},
    {16'h0000, 3'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1, 16'h08B6, 16'hFFFF},
    {16'h0000, 3'd1, 1'b1, 16'h0003, 16'h0005, 16'hFFFE, 1'b1, 1'b1, 16'h00B3, 16'hFFFF},
    {16'h0001, 3'd2, 1'b0, 16'h0001, 16'h0001, 16'h0000, 1'b0, 1'b0, 16'h0067, 16'hFFFF},
    {16'h0000, 3'd2, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1, 16'h08B6, 16'hFFFF},
    {16'h0811, 3'd3, 1'b1, 16'hF0F0, 16'h0FFF, 16'h00F0, 1'b1, 1'b0, 16'h0026, 16'hFFFF},
    {16'h0000, 3'd4, 1'b0, 16'h00C0, 16'h0001, 16'h0080, 1'b1, 1'b0, 16'h00A3, 16'hFFFF},
    {16'h0010, 3'd4, 1'b1, 16'hA000, 16'h0001, 16'h4000, 1'b1, 1'b0, 16'h0837, 16'hFFFF},
    {16'h0000, 3'd0, 1'b0, 16'h0080, 16'h0080, 16'h1200, 1'b1, 1'b0, 16'h0867, 16'hFFFF},
    {16'h0700, 3'd5, 1'b1, 16'h1234, 16'h0011, 16'h0112, 1'b1, 1'b1, 16'h0722, 16'hF72A}
  };
  localparam string VREQ [NV] = '{"R3 R4 R5 byte add", "R3 R4 word add overflow",
    "R3 R5 sub borrow", "R6 dec keeps carry=1", "R6 inc keeps carry=0",
    "R7 logical clears", "R8 byte shift", "R8 word shift keeps aux",
    "R4 byte ignores high bits", "R9 divide keeps controls"};

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] w);
    load = 1'b1; load_word = w;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] c);
    cmd_valid = 1'b1; cmd = c;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = 3'd7;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", flags, 16'h0022);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", flags, 16'h0022);

    for (int i = 0; i < NV; i++) begin
      logic [101:0] v;
      v = VEC[i];
      do_load(v[101:86]);
      upd = 1'b1; op_class = v[85:83]; is_word = v[82];
      opa = v[81:66]; opb = v[65:50]; res = v[49:34];
      c_out = v[33]; c_into_msb = v[32];
      @(negedge clk);
      upd = 1'b0;
      check(VREQ[i], flags & v[15:0], v[31:16] & v[15:0]);
    end

    // R11 R2: load writes only active bits
    do_load(16'hFFFF);
    check("R11 R2 load all ones", flags, 16'h0FF7);
    do_load(16'h0000);
    check("R11 R2 load zeros", flags, 16'h0022);

    // R10 commands, each from a known word
    do_cmd(3'd1); check("R10 set carry", flags, 16'h0023);
    do_cmd(3'd2); check("R10 invert carry", flags, 16'h0022);
    do_cmd(3'd2); check("R10 invert carry again", flags, 16'h0023);
    do_cmd(3'd4); check("R10 set interrupt-enable", flags, 16'h0223);
    do_cmd(3'd6); check("R10 set direction", flags, 16'h0623);
    do_cmd(3'd7); check("R10 no-op code", flags, 16'h0623);
    do_load(16'hFFFF);
    do_cmd(3'd0); check("R10 clear carry", flags, 16'h0FF6);
    do_cmd(3'd3); check("R10 clear interrupt-enable", flags, 16'h0DF6);
    do_cmd(3'd5); check("R10 clear direction", flags, 16'h09F6);

    // R12 priority: load over command over update
    do_load(16'h0000);
    load = 1'b1; load_word = 16'h0004; cmd_valid = 1'b1; cmd = 3'd1;
    upd = 1'b1; op_class = 3'd3; is_word = 1'b1; res = 16'h0000;
    @(negedge clk);
    load = 1'b0; cmd_valid = 1'b0; upd = 1'b0;
    check("R12 load wins", flags, 16'h0026);
    cmd_valid = 1'b1; cmd = 3'd1; upd = 1'b1; op_class = 3'd3; res = 16'h0000;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = 3'd7; upd = 1'b0;
    check("R12 command wins over update", flags, 16'h0027);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule